// File: doc/BRIEF.md
# Closest-Child Partial Distance Unit

This block is the pruning expansion stage used at the deeper levels of a breadth-first MIMO sphere detector. Every cycle it takes one surviving tree path per lane, each with its accumulated partial distance and the real-valued symbols already chosen for the levels above. It strips the interference of those symbols from the rotated received sample of the current level and picks the one constellation value that gives the smallest squared level error. It then forwards that single child in place of the full set of children, so the detector needs no K-best sort between levels.

The unit is built for the real-valued split of square QAM. Each real dimension carries an odd integer alphabet whose largest magnitude depends on the modulation code. The rotated sample, the diagonal coefficient and the upper-triangular coefficients of the level are shared by all lanes in a cycle. The distance, the history and the valid bit belong to each lane. Each output path carries the updated distance, the chosen symbol and the history with the new symbol appended, so that at the last level the full decided vector sits next to its distance. The pipeline has a fixed latency of three cycles and accepts a new path on every lane every cycle.

Top module: `closest_child_ped`

## Requirements
- R1: A path presented with its lane valid high on a rising edge leaves on the same lane with out_valid_o high exactly three rising edges later. A low valid gives a low out_valid_o three edges later.
- R2: While rst_ni is low, out_valid_o is all zero, even when in_valid_i is high.
- R3: The interference-cancelled sample is z = y_i minus the sum over j of r_off_i[j] times in_hist_i[lane][j], all as two's-complement values.
- R4: The chosen symbol is the odd value in the active alphabet that minimises |z - r_diag_i*s|, with r_diag_i taken as positive. The alphabet codes for mod_i are: 0 gives {-1,+1}; 1 gives {-3..+3}; 2 and 3 give {-7..+7}.
- R5: When z lies exactly halfway between two alphabet values (z = r_diag_i*k for an even k), the larger of the two is chosen. For example, z = 0 gives +1.
- R6: When z lies beyond the outermost alphabet value, the symbol is clipped to that value: +1/-1, +3/-3 or +7/-7, depending on mod_i.
- R7: out_pd_o equals in_pd_i plus (z - r_diag_i*s) squared, where s is the chosen symbol. A zero error leaves the distance unchanged.
- R8: When that sum exceeds 2^PD_W-1, out_pd_o saturates to 2^PD_W-1.
- R9: out_hist_o[lane][j] equals in_hist_i[lane][j] for j < NUM_DEEP, and out_hist_o[lane][NUM_DEEP] equals out_sym_o[lane].
- R10: Lanes are independent, and the shared inputs (mod_i, y_i, r_diag_i, r_off_i) apply only to the paths valid in the same cycle. A change on consecutive cycles affects only its own paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mod_i | input | 2 | Modulation code (0 QPSK, 1 16-QAM, 2/3 64-QAM) |
| y_i | input | Y_W | Rotated received sample of this level, signed |
| r_diag_i | input | R_W | Diagonal coefficient of this level, signed, positive |
| r_off_i | input | NUM_DEEP*R_W | Coefficients toward the deeper symbols, signed |
| in_valid_i | input | NUM_LANES | Path present per lane |
| in_pd_i | input | NUM_LANES*PD_W | Incoming partial distance per lane, unsigned |
| in_hist_i | input | NUM_LANES*NUM_DEEP*4 | Deeper symbols per lane, signed |
| out_valid_o | output | NUM_LANES | Result present per lane |
| out_pd_o | output | NUM_LANES*PD_W | Updated partial distance per lane |
| out_sym_o | output | NUM_LANES*4 | Chosen symbol per lane, signed |
| out_hist_o | output | NUM_LANES*(NUM_DEEP+1)*4 | History with the new symbol at the top index |

## Verification
The bench goes after exact halfway samples, including z = 0 and z = ±2·r_diag. A slicer that rounds ties the wrong way, or that uses strict comparison at the thresholds, returns the smaller symbol and the wrong distance. Samples far outside the alphabet for each modulation code check the clipping: a slicer that clips to the wrong magnitude for a code emits a symbol the constellation cannot hold. Distances near the top of the range check the saturation: an adder without saturation wraps to a small value and would promote a bad path. Random traffic changes the modulation and the coefficients every cycle, with sparse lane valids. This exposes any stage that samples the shared inputs at the wrong depth, or a valid that is misaligned with its data.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int SYM_W   = 4;
  localparam int SYM_MAX = 7;

  typedef enum logic [1:0] {
    MOD_QPSK  = 2'd0,
    MOD_QAM16 = 2'd1,
    MOD_QAM64 = 2'd2,
    MOD_ALT64 = 2'd3
  } mod_e;

  typedef logic signed [SYM_W-1:0] sym_t;

  function automatic sym_t max_mag(mod_e m);
    case (m)
      MOD_QPSK:  return sym_t'(1);
      MOD_QAM16: return sym_t'(3);
      default:   return sym_t'(SYM_MAX);
    endcase
  endfunction
endpackage

// File: rtl/ccp_interf.sv
module ccp_interf
  import ccp_pkg::*;
#(
  parameter int Y_W  = 16,
  parameter int R_W  = 16,
  parameter int PD_W = 32,
  parameter int ND   = 2,
  parameter int Z_W  = 23
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       vld_i,
  input  mod_e                       mod_i,
  input  logic [Y_W-1:0]             y_i,
  input  logic [R_W-1:0]             r_diag_i,
  input  logic [ND-1:0][R_W-1:0]     r_off_i,
  input  logic [PD_W-1:0]            pd_i,
  input  logic [ND-1:0][SYM_W-1:0]   hist_i,
  output logic                       vld_o,
  output mod_e                       mod_o,
  output logic [Z_W-1:0]             z_o,
  output logic [R_W-1:0]             r_diag_o,
  output logic [PD_W-1:0]            pd_o,
  output logic [ND-1:0][SYM_W-1:0]   hist_o
);
  logic signed [Z_W-1:0] z_d;

  always_comb begin
    z_d = Z_W'($signed(y_i));
    for (int j = 0; j < ND; j++) begin
      z_d = z_d - Z_W'($signed(r_off_i[j])) * Z_W'($signed(hist_i[j]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  always_ff @(posedge clk_i) begin
    if (vld_i) begin
      mod_o    <= mod_i;
      z_o      <= z_d;
      r_diag_o <= r_diag_i;
      pd_o     <= pd_i;
      hist_o   <= hist_i;
    end
  end

  AST_S1_VLD_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o); // R1
  AST_S1_VLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o); // R1
endmodule

// File: rtl/ccp_slicer.sv
module ccp_slicer
  import ccp_pkg::*;
#(
  parameter int R_W  = 16,
  parameter int PD_W = 32,
  parameter int ND   = 2,
  parameter int Z_W  = 23
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       vld_i,
  input  mod_e                       mod_i,
  input  logic [Z_W-1:0]             z_i,
  input  logic [R_W-1:0]             r_diag_i,
  input  logic [PD_W-1:0]            pd_i,
  input  logic [ND-1:0][SYM_W-1:0]   hist_i,
  output logic                       vld_o,
  output sym_t                       sym_o,
  output logic [Z_W-1:0]             z_o,
  output logic [R_W-1:0]             r_diag_o,
  output logic [PD_W-1:0]            pd_o,
  output logic [ND-1:0][SYM_W-1:0]   hist_o
);
  localparam int CMP_W = ((Z_W > R_W + 4) ? Z_W : R_W + 4) + 1;
  localparam int NTHR  = SYM_MAX;

  logic [NTHR-1:0]           ge;
  logic [SYM_W-1:0]          cnt;
  logic signed [SYM_W+1:0]   s_wide;
  logic signed [SYM_W+1:0]   amax_w;
  sym_t                      amax;
  sym_t                      sym_d;

  // decision boundaries sit at even multiples of the diagonal coefficient
  for (genvar k = 0; k < NTHR; k++) begin : g_thr
    localparam int LEV = 2 * k - (NTHR - 1);
    logic signed [CMP_W-1:0] thr;
    assign thr   = CMP_W'($signed(r_diag_i)) * CMP_W'(LEV);
    assign ge[k] = CMP_W'($signed(z_i)) >= thr;
  end

  always_comb begin
    cnt = '0;
    for (int k = 0; k < NTHR; k++) cnt = cnt + {{(SYM_W-1){1'b0}}, ge[k]};
    s_wide = $signed({1'b0, cnt, 1'b0}) - (SYM_W+2)'(NTHR);
    amax   = max_mag(mod_i);
    amax_w = (SYM_W+2)'(amax);
    if (s_wide > amax_w)       sym_d = amax;
    else if (s_wide < -amax_w) sym_d = -amax;
    else                       sym_d = sym_t'(s_wide);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  always_ff @(posedge clk_i) begin
    if (vld_i) begin
      sym_o    <= sym_d;
      z_o      <= z_i;
      r_diag_o <= r_diag_i;
      pd_o     <= pd_i;
      hist_o   <= hist_i;
    end
  end

  AST_S2_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o); // R1
  AST_SYM_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> sym_o[0]); // R4
  AST_SYM_CLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> (sym_o <= max_mag($past(mod_i))) && (sym_o >= -max_mag($past(mod_i)))); // R6
endmodule

// File: rtl/ccp_dist.sv
module ccp_dist
  import ccp_pkg::*;
#(
  parameter int R_W  = 16,
  parameter int PD_W = 32,
  parameter int ND   = 2,
  parameter int Z_W  = 23
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       vld_i,
  input  sym_t                       sym_i,
  input  logic [Z_W-1:0]             z_i,
  input  logic [R_W-1:0]             r_diag_i,
  input  logic [PD_W-1:0]            pd_i,
  input  logic [ND-1:0][SYM_W-1:0]   hist_i,
  output logic                       vld_o,
  output logic [PD_W-1:0]            pd_o,
  output sym_t                       sym_o,
  output logic [ND:0][SYM_W-1:0]     hist_o
);
  localparam int E_W   = ((Z_W > R_W + SYM_W) ? Z_W : R_W + SYM_W) + 1;
  localparam int SQ_W  = 2 * E_W;
  localparam int SUM_W = ((SQ_W > PD_W) ? SQ_W : PD_W) + 1;

  logic signed [E_W-1:0]  err;
  logic signed [SQ_W-1:0] sq_s;
  logic [SQ_W-1:0]        sq;
  logic [SUM_W-1:0]       sum;
  logic                   sat;
  logic [PD_W-1:0]        pd_d;

  always_comb begin
    err  = E_W'($signed(z_i)) - E_W'($signed(r_diag_i)) * E_W'(sym_i);
    sq_s = SQ_W'(err) * SQ_W'(err);
    sq   = sq_s;
    sum  = SUM_W'(pd_i) + SUM_W'(sq);
    sat  = |sum[SUM_W-1:PD_W];
    pd_d = sat ? {PD_W{1'b1}} : sum[PD_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  always_ff @(posedge clk_i) begin
    if (vld_i) begin
      pd_o   <= pd_d;
      sym_o  <= sym_i;
      hist_o <= {sym_i, hist_i};
    end
  end

  AST_S3_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o); // R1
  AST_PD_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> pd_o >= $past(pd_i)); // R7
  AST_PD_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (&pd_i)) |=> (&pd_o)); // R8
  AST_HIST_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> hist_o[ND-1:0] == $past(hist_i)); // R9
endmodule

// File: rtl/closest_child_ped.sv
module closest_child_ped
  import ccp_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int NUM_DEEP  = 2,
  parameter int Y_W       = 16,
  parameter int R_W       = 16,
  parameter int PD_W      = 32
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic [1:0]                                 mod_i,
  input  logic [Y_W-1:0]                             y_i,
  input  logic [R_W-1:0]                             r_diag_i,
  input  logic [NUM_DEEP-1:0][R_W-1:0]               r_off_i,
  input  logic [NUM_LANES-1:0]                       in_valid_i,
  input  logic [NUM_LANES-1:0][PD_W-1:0]             in_pd_i,
  input  logic [NUM_LANES-1:0][NUM_DEEP-1:0][3:0]    in_hist_i,
  output logic [NUM_LANES-1:0]                       out_valid_o,
  output logic [NUM_LANES-1:0][PD_W-1:0]             out_pd_o,
  output logic [NUM_LANES-1:0][3:0]                  out_sym_o,
  output logic [NUM_LANES-1:0][NUM_DEEP:0][3:0]      out_hist_o
);
  localparam int P_W = (Y_W > R_W + SYM_W) ? Y_W : R_W + SYM_W;
  localparam int Z_W = P_W + $clog2(NUM_DEEP + 1) + 1;

  mod_e mod_in;
  assign mod_in = mod_e'(mod_i);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic                           v1, v2;
    mod_e                           m1;
    logic [Z_W-1:0]                 z1, z2;
    logic [R_W-1:0]                 r1, r2;
    logic [PD_W-1:0]                p1, p2;
    logic [NUM_DEEP-1:0][SYM_W-1:0] h1, h2;
    sym_t                           s2, s3;

    ccp_interf #(.Y_W(Y_W), .R_W(R_W), .PD_W(PD_W), .ND(NUM_DEEP), .Z_W(Z_W)) i_interf (
      .clk_i, .rst_ni,
      .vld_i(in_valid_i[l]), .mod_i(mod_in), .y_i, .r_diag_i, .r_off_i,
      .pd_i(in_pd_i[l]), .hist_i(in_hist_i[l]),
      .vld_o(v1), .mod_o(m1), .z_o(z1), .r_diag_o(r1), .pd_o(p1), .hist_o(h1)
    );

    ccp_slicer #(.R_W(R_W), .PD_W(PD_W), .ND(NUM_DEEP), .Z_W(Z_W)) i_slicer (
      .clk_i, .rst_ni,
      .vld_i(v1), .mod_i(m1), .z_i(z1), .r_diag_i(r1), .pd_i(p1), .hist_i(h1),
      .vld_o(v2), .sym_o(s2), .z_o(z2), .r_diag_o(r2), .pd_o(p2), .hist_o(h2)
    );

    ccp_dist #(.R_W(R_W), .PD_W(PD_W), .ND(NUM_DEEP), .Z_W(Z_W)) i_dist (
      .clk_i, .rst_ni,
      .vld_i(v2), .sym_i(s2), .z_i(z2), .r_diag_i(r2), .pd_i(p2), .hist_i(h2),
      .vld_o(out_valid_o[l]), .pd_o(out_pd_o[l]), .sym_o(s3), .hist_o(out_hist_o[l])
    );

    assign out_sym_o[l] = s3;
  end

  AST_RST_QUIET: assert property (@(posedge clk_i) !rst_ni |-> out_valid_o == '0); // R2
endmodule

// File: tb/test_closest_child_ped.sv
`timescale 1ns/1ps
module test_closest_child_ped;
  localparam int NL = 8;
  localparam int ND = 2;
  localparam longint PD_MAX = 64'h0000_0000_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]                  mod;
  logic [15:0]                 y, rd;
  logic [ND-1:0][15:0]         ro;
  logic [NL-1:0]               iv;
  logic [NL-1:0][31:0]         ipd;
  logic [NL-1:0][ND-1:0][3:0]  ih;
  logic [NL-1:0]               ov;
  logic [NL-1:0][31:0]         opd;
  logic [NL-1:0][3:0]          osym;
  logic [NL-1:0][ND:0][3:0]    ohist;

  closest_child_ped #(.NUM_LANES(NL), .NUM_DEEP(ND)) i_closest_child_ped (
    .clk_i(clk), .rst_ni(rst_n), .mod_i(mod), .y_i(y), .r_diag_i(rd), .r_off_i(ro),
    .in_valid_i(iv), .in_pd_i(ipd), .in_hist_i(ih),
    .out_valid_o(ov), .out_pd_o(opd), .out_sym_o(osym), .out_hist_o(ohist)
  );

  int n_chk = 0, n_fail = 0, t = 0;
  logic   exp_v [4][NL];
  longint exp_pd[4][NL];
  int     exp_s [4][NL];
  int     exp_h [4][NL][ND];
  string  tag_s [4][NL];
  string  tag_p [4][NL];

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rnd(int lo, int hi);
    return lo + int'($urandom % 32'(hi - lo + 1));
  endfunction

  function automatic int amax_of(logic [1:0] m);
    return (m == 2'd0) ? 1 : (m == 2'd1) ? 3 : 7;
  endfunction

  function automatic longint labs(longint v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic record();
    int slot = t % 4;
    for (int l = 0; l < NL; l++) begin
      longint z, r, e, p, bd;
      int a, best;
      bit tie;
      exp_v[slot][l] = iv[l];
      z = longint'($signed(y));
      for (int j = 0; j < ND; j++) begin
        z -= longint'($signed(ro[j])) * longint'($signed(ih[l][j]));
        exp_h[slot][l][j] = int'($signed(ih[l][j]));
      end
      r = longint'($signed(rd));
      a = amax_of(mod);
      best = -a; bd = labs(z + r * a); tie = 1'b0;
      for (int s = -a + 2; s <= a; s += 2) begin
        longint d = labs(z - r * s);
        if (d == bd) tie = 1'b1;
        if (d <= bd) begin
          if (d < bd) tie = 1'b0;
          best = s; bd = d;
        end
      end
      exp_s[slot][l] = best;
      if (z > r * a || z < -r * a) tag_s[slot][l] = "R6 clip";
      else if (tie)                tag_s[slot][l] = "R5 tie";
      else                         tag_s[slot][l] = "R4 slice";
      e = z - r * best;
      p = longint'(ipd[l]) + e * e;
      if (p > PD_MAX) begin p = PD_MAX; tag_p[slot][l] = "R8 saturate"; end
      else tag_p[slot][l] = "R7/R3 distance";
      exp_pd[slot][l] = p;
    end
  endtask

  task automatic tick();
    int cs;
    record();
    @(posedge clk);
    @(negedge clk);
    t++;
    cs = (t + 1) % 4;
    for (int l = 0; l < NL; l++) begin
      chk("R1/R10 valid", longint'(ov[l]), longint'(exp_v[cs][l]));
      if (exp_v[cs][l]) begin
        chk(tag_p[cs][l], longint'(opd[l]), exp_pd[cs][l]);
        chk(tag_s[cs][l], longint'($signed(osym[l])), longint'(exp_s[cs][l]));
        for (int j = 0; j < ND; j++)
          chk("R9 history", longint'($signed(ohist[l][j])), longint'(exp_h[cs][l][j]));
        chk("R9 appended", longint'($signed(ohist[l][ND])), longint'(exp_s[cs][l]));
      end
    end
  endtask

  task automatic directed(logic [1:0] m, int yv, int rv, int o0, int o1, int h0, int h1, longint pd);
    mod = m; y = 16'(yv); rd = 16'(rv); ro[0] = 16'(o0); ro[1] = 16'(o1);
    for (int l = 0; l < NL; l++) begin
      iv[l] = 1'b1;
      ipd[l] = 32'(pd + longint'(l));
      ih[l][0] = 4'(h0); ih[l][1] = 4'(h1);
    end
    tick();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < 4; s++) for (int l = 0; l < NL; l++) exp_v[s][l] = 1'b0;
    mod = 2'd2; y = '0; rd = 16'd1; ro = '0; iv = '1; ipd = '0; ih = '0;
    for (int c = 0; c < 5; c++) begin
      @(posedge clk); @(negedge clk);
      chk("R2 reset valid", longint'(ov), 0);
    end
    iv = '0;
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) tick();

    directed(2'd2,   200, 100,   0,  0,  1,  1, 5);           // R5 tie up to +3
    directed(2'd2,  -200, 100,   0,  0,  1,  1, 5);           // R5 tie to -1
    directed(2'd2,     0, 100,   0,  0, -1,  1, 5);           // R5 zero gives +1
    directed(2'd0, 10000, 100,   0,  0,  1,  1, 0);           // R6 qpsk
    directed(2'd1,-10000, 100,   0,  0,  3, -3, 0);           // R6 16-qam
    directed(2'd3, 10000, 100,   0,  0,  7, -7, 0);           // R6 code 3
    directed(2'd2,   500, 100,   0,  0,  1,  1, 77);          // R7 zero error
    directed(2'd2,   600, 100,  50,-30,  3, -5, 9);           // R3 cancellation
    directed(2'd0, 20000,   1,   0,  0,  1,  1, 64'hFFFF_FFF0); // R8 saturate
    directed(2'd2,  -700, 100,   0,  0,  1,  1, 64'hFFFF_FFF7); // R8 max in
    iv = '0;
    for (int c = 0; c < 4; c++) tick();

    for (int c = 0; c < 3000; c++) begin   // R10 shared inputs change every cycle
      mod = 2'(rnd(0, 3));
      y   = 16'(rnd(-20000, 20000));
      rd  = 16'(rnd(1, 2000));
      for (int j = 0; j < ND; j++) ro[j] = 16'(rnd(-1000, 1000));
      for (int l = 0; l < NL; l++) begin
        iv[l]  = ($urandom % 4) != 0;
        ipd[l] = $urandom & 32'h7FFF_FFFF;
        for (int j = 0; j < ND; j++) ih[l][j] = 4'(2 * rnd(0, 7) - 7);
      end
      tick();
    end
    iv = '0;
    for (int c = 0; c < 4; c++) tick();

    summary();
    $finish;
  end
endmodule